// File: doc/BRIEF.md
# Random-Stall Clock Enable Gate

This block sits in front of a cryptographic datapath and drives its clock enable. The datapath advances in segments of a fixed number of enabled cycles. Between segments the gate stalls it for a random interval of one to five cycles, so that an operation's timing keeps no fixed relationship to the clock. Each interval is drawn from a fresh 32-bit word that the gate fetches from an external true-random source over a request/acknowledge port. The mapping is unbiased: a word that would skew the distribution is discarded and another is requested.

A lock input lets the surrounding system freeze jitter before a phase that needs deterministic timing. The gate honours the lock only at the end of an enabled segment, so no interval is cut short. From that point the enable stays high until the lock is released, and then a new interval is fetched. When the datapath reports that it is idle at the end of a stall, the gate fetches a second word and runs a burst of one to ten dummy operations. These operations drive a real XOR/rotate register, so they draw switching activity like genuine work.

Top module: `jitter_gate`

## Requirements
- R1: In the first cycle after synchronous reset, `rnd_req` is 1, `clk_en` is 0, `dummy_o` is 0 and `dummy_q` is all zeros.
- R2: After a stall word w is accepted (cycle with `rnd_req` and `rnd_ack` both 1), `clk_en` stays 0 for exactly 1 + (w mod 5) cycles, for every w other than 32'hFFFFFFFF.
- R3: A stall word equal to 32'hFFFFFFFF is discarded: in the next cycle `rnd_req` is still 1 and `clk_en` still 0.
- R4: While a request is outstanding and `rnd_ack` is 0, `rnd_req` stays 1 and `clk_en` stays 0, for any number of cycles.
- R5: When a stall (and any dummy burst) ends, `clk_en` is 1 for exactly RUN_LEN cycles. With `lock_i` low at the last of them, the next cycle raises `rnd_req` for a new stall word.
- R6: `lock_i` is sampled in the last enabled cycle of a segment. If it is 1, `clk_en` stays 1 and no request is made until `lock_i` is sampled 0, and `rnd_req` rises in the cycle after that. Lock never shortens a stall or a segment.
- R7: If `idle_i` is 1 in the last stall cycle, the gate requests a dummy word d. Words d of 32'hFFFFFFFA or above are discarded and re-requested. An accepted d gives 1 + (d mod 10) cycles with `dummy_o` 1 and `clk_en` 0, followed by the enabled segment.
- R8: Each dummy word d is the seed of its burst. On the burst's cycles counted from 0, `dummy_q` is XORed with d on even cycles and rotated left by one bit on odd cycles.
- R9: At most one of `rnd_req`, `clk_en` and `dummy_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rnd_req | output | 1 | Request for a random word |
| rnd_ack | input | 1 | Random word valid this cycle |
| rnd_word | input | RW (32) | Random word from the entropy source |
| lock_i | input | 1 | Freeze jitter at the next segment boundary |
| idle_i | input | 1 | Datapath idle; allows a dummy burst |
| clk_en | output | 1 | Clock enable to the cryptographic datapath |
| dummy_o | output | 1 | A dummy operation is executing this cycle |
| dummy_q | output | RW (32) | Dummy operation register |

## Verification
The bench builds the gate with its default interval ranges (1 to 5 stall cycles, 1 to 10 dummy operations) and a 32-bit word. These bring the two rejection thresholds, 32'hFFFFFFFF and 32'hFFFFFFFA, within reach as literal stimulus words. It shortens the enabled segment to RUN_LEN = 3, so many stall, lock and burst sequences fit in a short run. With that segment length, a lock raised mid-stall still has to outlast a whole segment before the freeze becomes visible.

// File: rtl/jg_pkg.sv
package jg_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_STALL  = 3'd1,
        ST_RUN    = 3'd2,
        ST_LOCK   = 3'd3,
        ST_DFETCH = 3'd4,
        ST_DUMMY  = 3'd5
    } jg_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/jg_range_map.sv
module jg_range_map #(
    parameter int RW = 32,
    parameter int LO = 1,
    parameter int HI = 5,
    parameter int VW = 8
) (
    input  logic [RW-1:0] word,
    output logic          ok,
    output logic [VW-1:0] val
);
    localparam int M = HI - LO + 1;
    localparam logic [63:0] SPAN  = 64'd1 << RW;
    localparam logic [63:0] LIMIT = SPAN - (SPAN % 64'(M));

    logic [63:0]   wide;
    logic [RW-1:0] rem;

    always_comb begin
        wide = 64'(word);
        ok   = wide < LIMIT;
        rem  = word % RW'(M);
        val  = VW'(rem) + VW'(LO);
    end
endmodule

// File: rtl/jg_dummy_alu.sv
module jg_dummy_alu #(
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [RW-1:0] seed_in,
    input  logic          step,
    output logic [RW-1:0] q
);
    logic [RW-1:0] seed;
    logic          odd;

    always_ff @(posedge clk) begin
        if (rst) begin
            seed <= '0;
            odd  <= 1'b0;
            q    <= '0;
        end else if (load) begin
            seed <= seed_in;
            odd  <= 1'b0;
        end else if (step) begin
            odd <= ~odd;
            if (odd) q <= {q[RW-2:0], q[RW-1]};
            else     q <= q ^ seed;
        end
    end
endmodule

// File: rtl/jitter_gate.sv
module jitter_gate
    import jg_pkg::*;
#(
    parameter int RW      = 32,
    parameter int S_MIN   = 1,
    parameter int S_MAX   = 5,
    parameter int D_MIN   = 1,
    parameter int D_MAX   = 10,
    parameter int RUN_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic          rnd_req,
    input  logic          rnd_ack,
    input  logic [RW-1:0] rnd_word,
    input  logic          lock_i,
    input  logic          idle_i,
    output logic          clk_en,
    output logic          dummy_o,
    output logic [RW-1:0] dummy_q
);
    localparam int MAXV = max3(S_MAX, D_MAX, RUN_LEN);
    localparam int CW   = $clog2(MAXV + 1);

    jg_state_e     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          s_ok, d_ok;
    logic [CW-1:0] s_val, d_val;
    logic          alu_load, alu_step;

    jg_range_map #(.RW(RW), .LO(S_MIN), .HI(S_MAX), .VW(CW)) i_stall_map (
        .word (rnd_word),
        .ok   (s_ok),
        .val  (s_val)
    );

    jg_range_map #(.RW(RW), .LO(D_MIN), .HI(D_MAX), .VW(CW)) i_dummy_map (
        .word (rnd_word),
        .ok   (d_ok),
        .val  (d_val)
    );

    jg_dummy_alu #(.RW(RW)) i_dummy_alu (
        .clk     (clk),
        .rst     (rst),
        .load    (alu_load),
        .seed_in (rnd_word),
        .step    (alu_step),
        .q       (dummy_q)
    );

    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        alu_load = 1'b0;
        alu_step = 1'b0;
        unique case (state)
            ST_FETCH: begin
                if (rnd_ack && s_ok) begin
                    state_n = ST_STALL;
                    cnt_n   = s_val;
                end
            end
            ST_STALL: begin
                if (cnt == CW'(1)) begin
                    if (idle_i) begin
                        state_n = ST_DFETCH;
                    end else begin
                        state_n = ST_RUN;
                        cnt_n   = CW'(RUN_LEN);
                    end
                end else begin
                    cnt_n = cnt - CW'(1);
                end
            end
            ST_DFETCH: begin
                if (rnd_ack && d_ok) begin
                    state_n  = ST_DUMMY;
                    cnt_n    = d_val;
                    alu_load = 1'b1;
                end
            end
            ST_DUMMY: begin
                alu_step = 1'b1;
                if (cnt == CW'(1)) begin
                    state_n = ST_RUN;
                    cnt_n   = CW'(RUN_LEN);
                end else begin
                    cnt_n = cnt - CW'(1);
                end
            end
            ST_RUN: begin
                if (cnt == CW'(1)) begin
                    state_n = lock_i ? ST_LOCK : ST_FETCH;
                end else begin
                    cnt_n = cnt - CW'(1);
                end
            end
            ST_LOCK: begin
                if (!lock_i) state_n = ST_FETCH;
            end
            default: state_n = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    assign rnd_req = (state == ST_FETCH) || (state == ST_DFETCH);
    assign clk_en  = (state == ST_RUN) || (state == ST_LOCK);
    assign dummy_o = (state == ST_DUMMY);
endmodule

// File: rtl/jg_checker.sv
module jg_checker #(
    parameter int S_MAX   = 5,
    parameter int D_MAX   = 10,
    parameter int RUN_LEN = 4
) (
    input logic clk,
    input logic rst,
    input logic rnd_req,
    input logic rnd_ack,
    input logic lock_i,
    input logic clk_en,
    input logic dummy_o
);
    logic        quiet;
    logic [15:0] quiet_cnt, dum_cnt, hi_cnt;

    assign quiet = !rnd_req && !clk_en && !dummy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt <= '0;
            dum_cnt   <= '0;
            hi_cnt    <= '0;
        end else begin
            quiet_cnt <= quiet ? ((quiet_cnt == 16'hFFFF) ? quiet_cnt : quiet_cnt + 16'd1) : 16'd0;
            dum_cnt   <= dummy_o ? ((dum_cnt == 16'hFFFF) ? dum_cnt : dum_cnt + 16'd1) : 16'd0;
            hi_cnt    <= clk_en ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
        end
    end

    // R2: a stall never exceeds the upper bound of the interval range
    assert_stall_bound_R2: assert property (@(posedge clk) disable iff (rst)
        quiet |-> (quiet_cnt < 16'(S_MAX)));

    // R4: an outstanding request is held until acknowledged
    assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        (rnd_req && !rnd_ack) |=> rnd_req);

    // R5: an enabled segment is never shorter than RUN_LEN
    assert_run_length_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> (hi_cnt >= 16'(RUN_LEN)));

    // R6: with lock high the enable is never withdrawn
    assert_lock_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (clk_en && lock_i) |=> clk_en);

    // R7: a dummy burst never exceeds its upper bound
    assert_dummy_bound_R7: assert property (@(posedge clk) disable iff (rst)
        dummy_o |-> (dum_cnt < 16'(D_MAX)));

    // R9: request, enable and dummy activity are mutually exclusive
    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rnd_req, clk_en, dummy_o}));
endmodule

bind jitter_gate jg_checker #(
    .S_MAX   (S_MAX),
    .D_MAX   (D_MAX),
    .RUN_LEN (RUN_LEN)
) i_jg_checker (
    .clk     (clk),
    .rst     (rst),
    .rnd_req (rnd_req),
    .rnd_ack (rnd_ack),
    .lock_i  (lock_i),
    .clk_en  (clk_en),
    .dummy_o (dummy_o)
);

// File: tb/test_jitter_gate.sv
`timescale 1ns/1ps
module test_jitter_gate;
    localparam int RW      = 32;
    localparam int RUN_LEN = 3;
    localparam int NVEC    = 10;

    // {stall word, expected stall length; 0 means discarded}
    localparam logic [39:0] VEC [NVEC] = '{
        {32'h0000_0000, 8'd1},
        {32'h0000_0001, 8'd2},
        {32'h0000_0004, 8'd5},
        {32'h0000_0005, 8'd1},
        {32'h0000_0007, 8'd3},
        {32'hFFFF_FFFF, 8'd0},
        {32'h0000_000D, 8'd4},
        {32'h1234_5678, 8'd2},
        {32'hFFFF_FFFE, 8'd5},
        {32'hDEAD_BEEF, 8'd5}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rnd_req;
    logic          rnd_ack = 1'b0;
    logic [RW-1:0] rnd_word = '0;
    logic          lock_i = 1'b0;
    logic          idle_i = 1'b0;
    logic          clk_en;
    logic          dummy_o;
    logic [RW-1:0] dummy_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [RW-1:0] q_exp = '0;

    always #2.5 clk = ~clk;

    jitter_gate #(.RW(RW), .RUN_LEN(RUN_LEN)) i_jitter_gate (
        .clk      (clk),
        .rst      (rst),
        .rnd_req  (rnd_req),
        .rnd_ack  (rnd_ack),
        .rnd_word (rnd_word),
        .lock_i   (lock_i),
        .idle_i   (idle_i),
        .clk_en   (clk_en),
        .dummy_o  (dummy_o),
        .dummy_q  (dummy_q)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic give_word(input logic [RW-1:0] w);
        while (!rnd_req) @(negedge clk);
        rnd_ack  = 1'b1;
        rnd_word = w;
        @(negedge clk);
        rnd_ack  = 1'b0;
        rnd_word = '0;
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (!clk_en && !rnd_req && !dummy_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (clk_en && !rnd_req) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure_dummy(output int n);
        n = 0;
        while (dummy_o && !clk_en) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [RW-1:0] burst_model(input logic [RW-1:0] q,
                                                  input logic [RW-1:0] s,
                                                  input int n);
        logic [RW-1:0] r;
        r = q;
        for (int k = 0; k < n; k++) begin
            if (k % 2 == 0) r = r ^ s;
            else            r = {r[RW-2:0], r[RW-1]};
        end
        return r;
    endfunction

    task automatic reset_dut();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        q_exp = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        int bad;
        @(negedge clk);
        reset_dut();
        // R1: reset state
        chk("R1 rnd_req after reset", rnd_req, 1);
        chk("R1 clk_en after reset", clk_en, 0);
        chk("R1 dummy_o after reset", dummy_o, 0);
        chk("R1 dummy_q after reset", dummy_q, 0);

        // Table walk: R2 stall lengths, R3 discard, R5 segment length
        for (int v = 0; v < NVEC; v++) begin
            give_word(VEC[v][39:8]);
            if (VEC[v][7:0] == 8'd0) begin
                chk("R3 request kept after discarded word", rnd_req, 1);
                chk("R3 enable low after discarded word", clk_en, 0);
            end else begin
                measure_low(n);
                chk("R2 stall length", n, VEC[v][7:0]);
                measure_high(n);
                chk("R5 segment length", n, RUN_LEN);
                chk("R5 new request after segment", rnd_req, 1);
            end
        end

        // R4: no acknowledge, enable held low and request held high
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            if (!rnd_req || clk_en || dummy_o) bad++;
            @(negedge clk);
        end
        chk("R4 waiting cycles with wrong outputs", bad, 0);

        // R6: lock raised during a stall
        give_word(32'h0000_0002);
        lock_i = 1'b1;
        measure_low(n);
        chk("R6 stall not shortened by lock", n, 3);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (!clk_en || rnd_req) bad++;
            @(negedge clk);
        end
        chk("R6 locked cycles with wrong outputs", bad, 0);
        lock_i = 1'b0;
        @(negedge clk);
        chk("R6 request after unlock", rnd_req, 1);
        chk("R6 enable low after unlock", clk_en, 0);

        // R7/R8: first dummy burst, with a discarded dummy word
        idle_i = 1'b1;
        give_word(32'h0000_0000);
        measure_low(n);
        chk("R2 stall before burst", n, 1);
        chk("R7 dummy word requested", rnd_req, 1);
        give_word(32'hFFFF_FFFA);
        chk("R7 discarded dummy word re-requested", rnd_req, 1);
        chk("R7 no dummy op after discard", dummy_o, 0);
        give_word(32'h0000_0005);
        idle_i = 1'b0;
        measure_dummy(n);
        chk("R7 burst length", n, 6);
        q_exp = burst_model(q_exp, 32'h0000_0005, 6);
        chk("R8 dummy register after burst", dummy_q, q_exp);
        measure_high(n);
        chk("R5 segment after burst", n, RUN_LEN);

        // R7/R8: longest burst, seeded by the largest accepted word
        idle_i = 1'b1;
        give_word(32'h0000_0003);
        measure_low(n);
        chk("R2 stall before second burst", n, 4);
        give_word(32'hFFFF_FFF9);
        idle_i = 1'b0;
        measure_dummy(n);
        chk("R7 longest burst length", n, 10);
        q_exp = burst_model(q_exp, 32'hFFFF_FFF9, 10);
        chk("R8 dummy register after second burst", dummy_q, q_exp);

        // R1: reset in the middle of a segment
        reset_dut();
        chk("R1 rnd_req after mid-run reset", rnd_req, 1);
        chk("R1 clk_en after mid-run reset", clk_en, 0);
        chk("R1 dummy_q after mid-run reset", dummy_q, 0);

        finish_run();
    end
endmodule